// File: doc/BRIEF.md
# Zero-Free Byte Stuffing Frame Transmitter

This block turns a raw payload of up to 254 bytes into a self-delimiting frame in which the value 0x00 appears only once, as the final byte. The payload is first written into an internal byte store through a simple write port. A start strobe then launches the encoding. The strobe carries the payload length, which may be anywhere from 0 to 254 bytes.

The encoder walks the stored payload in runs. A run is a stretch of non-zero bytes ended either by a zero or by the end of the payload. For each run the encoder scans ahead to find where the run ends. It then sends one code byte, worth the run length plus one, followed by the run's bytes in their original order. A payload zero is never sent, because the code byte of the run that follows it stands for its position. After the last run the encoder closes the frame with a single 0x00.

Output bytes leave one at a time on a valid/ready stream, normally towards a UART transmit path. A busy flag covers the whole frame.

Top module: `cobs_tx`

## Requirements
- R1: After reset, busy and out_valid are both 0.
- R2: Each run of non-zero payload bytes is sent as one code byte equal to the run length plus one, followed by the run bytes in payload order. For example, payload 11 22 00 33 gives 03 11 22 02 33 00.
- R3: A payload byte of value 0x00 is not sent, and back-to-back zeros each produce a code byte 0x01. For example, payload 11 00 00 00 gives 02 11 01 01 01 00, and a single zero byte gives 01 01 00.
- R4: Each frame ends with exactly one 0x00 byte, and no other byte of the frame is 0x00.
- R5: A start with length 0 produces the frame 01 00.
- R6: A payload of 254 non-zero bytes produces code byte 0xFF, then the 254 bytes, then 00.
- R7: While out_valid is 1 and out_ready is 0, out_valid and out_data hold their values into the next cycle.
- R8: busy rises in the cycle after an accepted start. It falls in the cycle after the delimiter is accepted, and out_valid is 1 only while busy is 1.
- R9: A start strobe while busy is ignored, and the frame in progress continues unchanged.
- R10: A start whose length exceeds 254 is ignored, and busy stays 0.
- R11: Payload writes while busy are ignored. Writes to an address of 254 or above are also ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Payload store write enable |
| wr_addr | input | 8 | Payload byte index |
| wr_data | input | 8 | Payload byte value |
| start | input | 1 | Begin encoding a frame |
| len | input | 8 | Payload length in bytes, sampled with start |
| busy | output | 1 | Frame in progress |
| out_valid | output | 1 | Encoded byte available |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Encoded byte |

## Verification
The run pointer, run length and end-of-payload flag can go wrong. Any such fault shows up at the output as a wrong or misplaced code byte, a dropped or repeated run byte, or a 0x00 that appears early. The error appears within the run where it starts. The bench therefore compares every frame byte for byte against an encoding computed from the requirements. It does so under constant readiness and under random back-pressure. A fault in the state machine that loses or extends a frame shows up at busy. The bench checks that busy falls exactly one cycle after the delimiter is accepted, and that no byte follows the delimiter.

// File: rtl/cobs_tx_pkg.sv
`timescale 1ns/1ps
package cobs_tx_pkg;
    // Largest payload that a single code byte can cover without splitting.
    localparam int LEN_LIMIT = 254;
    localparam logic [7:0] DELIM_BYTE = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_CODE,
        ST_DATA,
        ST_DELIM
    } tx_state_e;

    // A run of n non-zero bytes is announced by n+1.
    function automatic logic [7:0] run_code(input logic [7:0] run_len);
        return run_len + 8'd1;
    endfunction
endpackage

// File: rtl/cobs_tx_buf.sv
`timescale 1ns/1ps
module cobs_tx_buf #(
    parameter int MAX_LEN = 254,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int IW = $clog2(MAX_LEN);

    logic [7:0] mem [MAX_LEN];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr[IW-1:0]] <= wdata;
        end
    end

    // Reads past the stored range return zero; the scanner never uses them.
    assign rdata = (raddr < AW'(MAX_LEN)) ? mem[raddr[IW-1:0]] : 8'h00;
endmodule

// File: rtl/cobs_tx_ctrl.sv
`timescale 1ns/1ps
module cobs_tx_ctrl
    import cobs_tx_pkg::*;
#(
    parameter int MAX_LEN = 254,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] len,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          busy,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [7:0]    out_data
);
    tx_state_e     state;
    logic [AW-1:0] ptr;        // scan position, then emit position
    logic [AW-1:0] run_len;    // non-zero bytes in the current run
    logic [AW-1:0] remain;     // run bytes still to emit
    logic [AW-1:0] frame_len;
    logic          at_end;     // run closed by end of payload, not by a zero

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ptr       <= '0;
            run_len   <= '0;
            remain    <= '0;
            frame_len <= '0;
            at_end    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start && (int'(len) <= MAX_LEN)) begin
                        frame_len <= len;
                        ptr       <= '0;
                        run_len   <= '0;
                        state     <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (ptr == frame_len) begin
                        at_end <= 1'b1;
                        state  <= ST_CODE;
                    end else if (rd_data == 8'h00) begin
                        at_end <= 1'b0;
                        state  <= ST_CODE;
                    end else begin
                        ptr     <= ptr + AW'(1);
                        run_len <= run_len + AW'(1);
                    end
                end
                ST_CODE: begin
                    if (out_ready) begin
                        if (run_len == '0) begin
                            if (at_end) begin
                                state <= ST_DELIM;
                            end else begin
                                ptr   <= ptr + AW'(1);   // step over the zero
                                state <= ST_SCAN;
                            end
                        end else begin
                            ptr    <= ptr - run_len;     // rewind to run start
                            remain <= run_len;
                            state  <= ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    if (out_ready) begin
                        if (remain == AW'(1)) begin
                            run_len <= '0;
                            if (at_end) begin
                                state <= ST_DELIM;
                            end else begin
                                ptr   <= ptr + AW'(2);   // past the zero
                                state <= ST_SCAN;
                            end
                        end else begin
                            ptr    <= ptr + AW'(1);
                            remain <= remain - AW'(1);
                        end
                    end
                end
                ST_DELIM: begin
                    if (out_ready) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rd_addr   = ptr;
    assign busy      = (state != ST_IDLE);
    assign out_valid = (state == ST_CODE) || (state == ST_DATA) || (state == ST_DELIM);

    always_comb begin
        unique case (state)
            ST_CODE: out_data = run_code(8'(run_len));
            ST_DATA: out_data = rd_data;
            default: out_data = DELIM_BYTE;
        endcase
    end
endmodule

// File: rtl/cobs_tx.sv
`timescale 1ns/1ps
module cobs_tx #(
    parameter int MAX_LEN = 254,
    localparam int AW = $clog2(MAX_LEN + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          start,
    input  logic [AW-1:0] len,
    output logic          busy,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [7:0]    out_data
);
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic          store_we;

    // The store is frozen for the whole frame so that a stall never sees new data.
    assign store_we = wr_en && !busy && (wr_addr < AW'(MAX_LEN));

    cobs_tx_buf #(.MAX_LEN(MAX_LEN), .AW(AW)) i_buf (
        .clk   (clk),
        .we    (store_we),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    cobs_tx_ctrl #(.MAX_LEN(MAX_LEN), .AW(AW)) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .len       (len),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .busy      (busy),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );
endmodule

// File: rtl/cobs_tx_chk.sv
`timescale 1ns/1ps
module cobs_tx_chk #(
    parameter int MAX_LEN = 254,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [AW-1:0] len,
    input logic          busy,
    input logic          out_valid,
    input logic          out_ready,
    input logic [7:0]    out_data
);
    p_valid_in_frame_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> busy);

    p_hold_on_stall_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_delim_closes_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_data == 8'h00) |=> (!busy && !out_valid));

    p_launch_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && int'(len) <= MAX_LEN) |=> busy);

    p_overlen_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && int'(len) > MAX_LEN) |=> !busy);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> !out_valid);
endmodule

bind cobs_tx cobs_tx_chk #(.MAX_LEN(MAX_LEN), .AW(AW)) i_cobs_tx_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .len       (len),
    .busy      (busy),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/test_cobs_tx.sv
`timescale 1ns/1ps
module test_cobs_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       start = 1'b0;
    logic [7:0] len = '0;
    logic       busy;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_data;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    int delim_cyc = -1;
    bit bp = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0] pay [254];
    logic [7:0] got [$];
    logic [7:0] exp_q [$];
    bit   stall_prev = 1'b0;
    logic [7:0] stall_data = '0;

    cobs_tx i_cobs_tx (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .start(start), .len(len), .busy(busy), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    // Output monitor: sampled at the falling edge, transfer happens at the next rise.
    always @(negedge clk) begin
        if (!rst) begin
            if (stall_prev)
                check(out_valid && out_data == stall_data, "R7 hold on stall",
                      int'(out_data), int'(stall_data));
            stall_prev = out_valid && !out_ready;
            stall_data = out_data;
            if (out_valid && out_ready) begin
                got.push_back(out_data);
                if (out_data == 8'h00) delim_cyc = cyc;
            end
        end
    end

    // Ready driver: constant or pseudo-random back-pressure.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = bp ? lfsr[0] : 1'b1;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    task automatic load(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            wr_en = 1'b1; wr_addr = 8'(i); wr_data = pay[i];
        end
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // Reference encoding built directly from R2-style rules (code = run + 1).
    task automatic build_expect(input int n);
        int ci;
        int code;
        exp_q.delete();
        ci = 0; code = 1;
        exp_q.push_back(8'h00);
        for (int i = 0; i < n; i++) begin
            if (pay[i] == 8'h00) begin
                exp_q[ci] = 8'(code);
                ci = exp_q.size();
                exp_q.push_back(8'h00);
                code = 1;
            end else begin
                exp_q.push_back(pay[i]);
                code++;
            end
        end
        exp_q[ci] = 8'(code);
        exp_q.push_back(8'h00);
    endtask

    // Runs one frame; optional disturbance in the middle (second start, store write).
    task automatic run_frame(input int n, input string req, input bit disturb);
        int guard;
        int low_cyc;
        int bad;
        build_expect(n);
        got.delete();
        delim_cyc = -1;
        @(posedge clk); #1;
        start = 1'b1; len = 8'(n);
        @(posedge clk); #1;
        start = 1'b0;
        check(busy == 1'b1, "R8 busy after start", int'(busy), 1);
        guard = 0;
        forever begin
            @(negedge clk);
            if (!busy) break;
            guard++;
            if (disturb && guard == 5) begin start = 1'b1; len = 8'd3; end
            if (disturb && guard == 6) begin start = 1'b0; end
            if (disturb && guard == 7) begin wr_en = 1'b1; wr_addr = 8'd0; wr_data = 8'h00; end
            if (disturb && guard == 8) begin wr_en = 1'b0; end
            if (guard > 5000) break;
        end
        low_cyc = cyc;
        check(got.size() == exp_q.size(), {req, " frame length"}, got.size(), exp_q.size());
        bad = -1;
        for (int i = 0; i < exp_q.size() && i < got.size(); i++)
            if (bad < 0 && got[i] != exp_q[i]) bad = i;
        check(bad < 0, {req, " frame bytes"}, (bad < 0) ? 0 : int'(got[bad]),
              (bad < 0) ? 0 : int'(exp_q[bad]));
        bad = 0;
        for (int i = 0; i + 1 < got.size(); i++)
            if (got[i] == 8'h00) bad++;
        check(bad == 0, "R4 no inner zero", bad, 0);
        check(low_cyc == delim_cyc + 1, "R8 busy falls after delimiter", low_cyc, delim_cyc + 1);
        repeat (3) @(negedge clk);
        check(!out_valid && got.size() == exp_q.size(), "R8 nothing after frame",
              got.size(), exp_q.size());
    endtask

    task automatic t_reset();
        check(busy == 1'b0, "R1 busy at reset", int'(busy), 0);
        check(out_valid == 1'b0, "R1 valid at reset", int'(out_valid), 0);
    endtask

    task automatic t_example_runs();
        pay[0] = 8'h11; pay[1] = 8'h22; pay[2] = 8'h00; pay[3] = 8'h33;
        load(4);
        run_frame(4, "R2 example 11 22 00 33", 1'b0);
        check(got.size() == 6 && got[0] == 8'h03 && got[3] == 8'h02, "R2 code bytes",
              (got.size() > 3) ? int'(got[3]) : -1, 2);
    endtask

    task automatic t_zero_runs();
        pay[0] = 8'h11; pay[1] = 8'h00; pay[2] = 8'h00; pay[3] = 8'h00;
        load(4);
        run_frame(4, "R3 example 11 00 00 00", 1'b0);
        pay[0] = 8'h00;
        load(1);
        run_frame(1, "R3 lone zero", 1'b0);
        check(got.size() == 3 && got[0] == 8'h01 && got[1] == 8'h01, "R3 lone zero codes",
              (got.size() > 1) ? int'(got[1]) : -1, 1);
    endtask

    task automatic t_empty();
        run_frame(0, "R5 empty payload", 1'b0);
        check(got.size() == 2 && got[0] == 8'h01, "R5 code 01", got.size(), 2);
    endtask

    task automatic t_max_run();
        for (int i = 0; i < 254; i++) pay[i] = 8'((i % 255) + 1);
        load(254);
        bp = 1'b1;
        run_frame(254, "R6 max run", 1'b0);
        bp = 1'b0;
        check(got.size() == 256 && got[0] == 8'hFF, "R6 code FF",
              (got.size() > 0) ? int'(got[0]) : -1, 255);
    endtask

    task automatic t_all_zero();
        for (int i = 0; i < 254; i++) pay[i] = 8'h00;
        load(254);
        run_frame(254, "R3 all zero 254", 1'b0);
    endtask

    task automatic t_mixed_bp();
        logic [7:0] s;
        s = 8'h5A;
        for (int i = 0; i < 60; i++) begin
            s = {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
            pay[i] = (s[2:0] == 3'd0) ? 8'h00 : s;
        end
        pay[59] = 8'h00;
        load(60);
        bp = 1'b1;
        run_frame(60, "R2 mixed back-pressure", 1'b0);
        bp = 1'b0;
    endtask

    task automatic t_disturb();
        for (int i = 0; i < 20; i++) pay[i] = (i % 6 == 3) ? 8'h00 : 8'(i + 8'h40);
        load(20);
        bp = 1'b1;
        run_frame(20, "R9 start while busy", 1'b1);
        run_frame(20, "R11 write while busy", 1'b0);
        bp = 1'b0;
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = 8'd254; wr_data = 8'h77;
        @(posedge clk); #1;
        wr_en = 1'b0;
        run_frame(20, "R11 out-of-range write", 1'b0);
    endtask

    task automatic t_overlen();
        got.delete();
        @(posedge clk); #1;
        start = 1'b1; len = 8'd255;
        @(posedge clk); #1;
        start = 1'b0;
        check(busy == 1'b0, "R10 over-length start", int'(busy), 0);
        repeat (5) @(negedge clk);
        check(busy == 1'b0 && got.size() == 0, "R10 no output", got.size(), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst = 1'b0;
        @(posedge clk); #1;
        t_example_runs();
        t_zero_runs();
        t_empty();
        t_max_run();
        t_all_zero();
        t_mixed_bp();
        t_disturb();
        t_overlen();
        summary();
        $finish;
    end
endmodule